// File: doc/BRIEF.md
# Tuner Control Register Serial Slave

This block is a two-wire serial (I2C) slave that holds the programming of a synthesised downconversion tuner. The host writes a 15-bit loop divider word and a set of control fields (charge-pump current, reference ratio, test mode, oscillator select, baseband path select, reference buffer enable and a general-purpose port bit). Each field is exposed on its own output port for the analog and synthesiser logic. In the other direction, the host reads back a status byte that carries a power-on flag and the loop lock flag.

Both bus lines are sampled by the system clock through a synchroniser, and edges are detected on the sampled values. SDA is driven only as an active-high "pull low" enable for an external open-drain pad. The slave address has a fixed five-bit prefix, followed by two bits taken from a strap input.

After the address, data arrives in byte pairs. The most significant bit of the first byte in each pair chooses between a frequency pair and a control pair. The divider output changes only as a whole, so a synthesiser that is being fine-tuned never sees half of a new word.

Top module: `tuner_i2c_top`

## Requirements
- R1: After reset, divWord, cpCurrent, refRatio, testMode, oscSel and pathSel are zero, refBufEn is 1, portP0 is 0, and sdaDriveLow is 0.
- R2: The slave answers only the address byte {1,1,0,0,0,addrStrap[1],addrStrap[0],rw}, sent MSB first. It acknowledges a match by pulling SDA low in the ninth clock. A mismatch is not acknowledged, and the slave ignores all bytes until the next START.
- R3: In write mode, every data byte is acknowledged. A first-of-pair byte with bit 7 = 0 carries divider bits 14..8 in bits 6..0. The byte that follows it carries divider bits 7..0.
- R4: divWord keeps its old value after only the upper frequency byte has arrived. It takes the new 15-bit value when the lower byte completes. If a STOP comes first, it takes {new upper bits, previous bits 7..0}.
- R5: A first-of-pair byte with bit 7 = 1 sets cpCurrent from bits 6..5 and refRatio from bits 4..0. The byte that follows it sets testMode from bits 7..5, oscSel from bit 4, pathSel from bit 3, refBufEn from bit 1 and portP0 from bit 0; bit 2 is ignored.
- R6: Further byte pairs in the same transaction are decoded by the same bit-7 rule, with no new address byte, until a STOP.
- R7: A STOP inside a byte discards the partial byte. All fields from completed bytes are kept.
- R8: In read mode, the slave sends status bytes {porFlag, lockIn, 6'b0}, MSB first. It sends another byte each time the master acknowledges.
- R9: When the master does not acknowledge a status byte, the slave releases SDA and ends the transaction as if a STOP had occurred. It drives nothing until the next START.
- R10: porFlag is set by reset and by porEvent. It is cleared when a read transaction ends, either by a STOP or by a missing master acknowledge.
- R11: A repeated START restarts address reception at any point, including a switch from write mode to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| addrStrap | input | 2 | Variable address bits from the strap |
| porEvent | input | 1 | Supply-drop indication; sets the power-on flag |
| lockIn | input | 1 | Loop lock indication, reported in status |
| sdaDriveLow | output | 1 | 1 = pull SDA low (open-drain enable) |
| divWord | output | 15 | Loop divider ratio |
| cpCurrent | output | 2 | Charge-pump current code |
| refRatio | output | 5 | Reference divider ratio code |
| testMode | output | 3 | Test mode code |
| oscSel | output | 1 | Local oscillator select |
| pathSel | output | 1 | Baseband filter path select |
| refBufEn | output | 1 | Reference buffer output enable |
| portP0 | output | 1 | General-purpose port state |

## Verification
The bench first sends only the upper frequency byte and checks that divWord has not moved. A design that committed each byte as it arrived would expose a half-written divider at that point. A STOP placed three bits into a control byte must leave the earlier fields intact; a design that latched the partial shift register would corrupt the test mode. The bench reads past a master no-acknowledge to catch a slave that keeps driving data bits. It also sends an address with the wrong strap bits and checks that no acknowledge follows and no register changes. Finally, a repeated START from write into read confirms that the pending upper frequency bits survive and are committed by the final STOP.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int DIV_W = 15;
  localparam int HI_W = DIV_W - 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } busState_t;

  // one-cycle strobes from the bus controller to the register file
  typedef struct packed {
    logic       addrOk;
    logic       byteValid;
    logic [7:0] byteData;
    logic       stopSeen;
    logic       readEnd;
  } ctrlStb_t;
endpackage

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_FIXED = 5'b11000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] addrStrap,
  input  logic [7:0] statusByte,
  output ctrlStb_t   stb,
  output logic       sdaDriveLow,
  output busState_t  state
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;
  logic [2:0] bitCnt;
  logic [7:0] shiftReg, txReg;
  logic byteDone, rwBit, mAck, readSess;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin sclPipe <= '1; sdaPipe <= '1; end
        else begin sclPipe <= sclIn; sdaPipe <= sdaIn; end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin sclPipe <= '1; sdaPipe <= '1; end
        else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin sclD <= 1'b1; sdaD <= 1'b1; end
    else begin sclD <= sclS; sdaD <= sdaS; end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      stb <= '0;
      sdaDriveLow <= 1'b0;
      bitCnt <= '0;
      shiftReg <= '0;
      txReg <= '0;
      byteDone <= 1'b0;
      rwBit <= 1'b0;
      mAck <= 1'b0;
      readSess <= 1'b0;
    end else begin
      stb <= '0;
      if (startDet) begin
        state <= S_ADDR;
        bitCnt <= '0;
        byteDone <= 1'b0;
        sdaDriveLow <= 1'b0;
        readSess <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE;
        sdaDriveLow <= 1'b0;
        stb.stopSeen <= 1'b1;
        stb.readEnd <= readSess;
        readSess <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR, S_WDATA: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) byteDone <= 1'b1;
            end else if (sclFall && byteDone) begin
              byteDone <= 1'b0;
              bitCnt <= '0;
              if (state == S_ADDR) begin
                if (shiftReg[7:1] == {ADDR_FIXED, addrStrap}) begin
                  sdaDriveLow <= 1'b1;
                  rwBit <= shiftReg[0];
                  readSess <= shiftReg[0];
                  stb.addrOk <= 1'b1;
                  state <= S_AACK;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                sdaDriveLow <= 1'b1;
                stb.byteValid <= 1'b1;
                stb.byteData <= shiftReg;
                state <= S_WACK;
              end
            end
          end
          S_AACK: begin
            if (sclFall) begin
              if (rwBit) begin
                txReg <= {statusByte[6:0], 1'b0};
                sdaDriveLow <= ~statusByte[7];
                bitCnt <= '0;
                state <= S_RDATA;
              end else begin
                sdaDriveLow <= 1'b0;
                state <= S_WDATA;
              end
            end
          end
          S_WACK: begin
            if (sclFall) begin
              sdaDriveLow <= 1'b0;
              state <= S_WDATA;
            end
          end
          S_RDATA: begin
            if (sclFall) begin
              if (bitCnt == 3'd7) begin
                sdaDriveLow <= 1'b0;
                bitCnt <= '0;
                state <= S_RACK;
              end else begin
                sdaDriveLow <= ~txReg[7];
                txReg <= {txReg[6:0], 1'b0};
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end
          S_RACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                txReg <= {statusByte[6:0], 1'b0};
                sdaDriveLow <= ~statusByte[7];
                state <= S_RDATA;
              end else begin
                stb.readEnd <= 1'b1;
                readSess <= 1'b0;
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic             porEvent,
  input  logic             lockIn,
  output logic [DIV_W-1:0] divWord,
  output logic [1:0]       cpCurrent,
  output logic [4:0]       refRatio,
  output logic [2:0]       testMode,
  output logic             oscSel,
  output logic             pathSel,
  output logic             refBufEn,
  output logic             portP0,
  output logic [7:0]       statusByte
);
  logic porFlag, lockQ, pairSecond, pairIsCtrl, hiValid;
  logic [HI_W-1:0] hiPend;

  assign statusByte = {porFlag, lockQ, 6'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porFlag <= 1'b1;
      lockQ <= 1'b0;
    end else begin
      lockQ <= lockIn;
      if (porEvent) porFlag <= 1'b1;
      else if (stb.readEnd) porFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divWord <= '0;
      cpCurrent <= '0;
      refRatio <= '0;
      testMode <= '0;
      oscSel <= 1'b0;
      pathSel <= 1'b0;
      refBufEn <= 1'b1;
      portP0 <= 1'b0;
      pairSecond <= 1'b0;
      pairIsCtrl <= 1'b0;
      hiValid <= 1'b0;
      hiPend <= '0;
    end else begin
      if (stb.addrOk) pairSecond <= 1'b0;
      if (stb.stopSeen) begin
        pairSecond <= 1'b0;
        hiValid <= 1'b0;
        if (hiValid) divWord <= {hiPend, divWord[7:0]};
      end else if (stb.byteValid) begin
        if (!pairSecond) begin
          pairSecond <= 1'b1;
          pairIsCtrl <= stb.byteData[7];
          if (!stb.byteData[7]) begin
            hiPend <= stb.byteData[HI_W-1:0];
            hiValid <= 1'b1;
          end else begin
            cpCurrent <= stb.byteData[6:5];
            refRatio <= stb.byteData[4:0];
          end
        end else begin
          pairSecond <= 1'b0;
          if (!pairIsCtrl) begin
            divWord <= {hiPend, stb.byteData};
            hiValid <= 1'b0;
          end else begin
            testMode <= stb.byteData[7:5];
            oscSel <= stb.byteData[4];
            pathSel <= stb.byteData[3];
            refBufEn <= stb.byteData[1];
            portP0 <= stb.byteData[0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/tuner_i2c_top.sv
module tuner_i2c_top
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_FIXED = 5'b11000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [1:0]  addrStrap,
  input  logic        porEvent,
  input  logic        lockIn,
  output logic        sdaDriveLow,
  output logic [14:0] divWord,
  output logic [1:0]  cpCurrent,
  output logic [4:0]  refRatio,
  output logic [2:0]  testMode,
  output logic        oscSel,
  output logic        pathSel,
  output logic        refBufEn,
  output logic        portP0
);
  ctrlStb_t ctrlStb;
  busState_t busState;
  logic [7:0] statusByte;

  tuner_i2c_ctrl #(.SYNC_STAGES(SYNC_STAGES), .ADDR_FIXED(ADDR_FIXED)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .statusByte(statusByte),
    .stb(ctrlStb), .sdaDriveLow(sdaDriveLow), .state(busState)
  );

  tuner_i2c_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .porEvent(porEvent), .lockIn(lockIn),
    .divWord(divWord), .cpCurrent(cpCurrent), .refRatio(refRatio),
    .testMode(testMode), .oscSel(oscSel), .pathSel(pathSel),
    .refBufEn(refBufEn), .portP0(portP0), .statusByte(statusByte)
  );
endmodule

// File: rtl/tuner_i2c_chk.sv
module tuner_i2c_chk
  import tuner_i2c_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaDriveLow,
  input logic [14:0] divWord,
  input logic [1:0]  cpCurrent,
  input logic [4:0]  refRatio,
  input ctrlStb_t    stb,
  input busState_t   state
);
  // R2: the slave only starts pulling SDA low while SCL is low
  p_drive_low_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);

  // R4: divider moves only on a completed byte or a STOP
  p_div_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divWord) |-> $past(stb.byteValid || stb.stopSeen));

  // R5: control fields move only on a completed byte
  p_ctrl_update_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({cpCurrent, refRatio}) |-> $past(stb.byteValid));

  // R6: bus events reach the register file one at a time
  p_single_event_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.addrOk, stb.byteValid, stb.stopSeen}));

  // R9: SDA is released while the master owns the acknowledge slot
  p_release_master_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RACK) |-> !sdaDriveLow);
endmodule

bind tuner_i2c_top tuner_i2c_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .divWord(divWord), .cpCurrent(cpCurrent), .refRatio(refRatio),
  .stb(ctrlStb), .state(busState)
);

// File: tb/tb_tuner_i2c_top.sv
module tb_tuner_i2c_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, sclM, sdaM, porEvent, lockIn;
  logic [1:0] addrStrap;
  logic sdaDriveLow, oscSel, pathSel, refBufEn, portP0;
  logic [14:0] divWord;
  logic [1:0] cpCurrent;
  logic [4:0] refRatio;
  logic [2:0] testMode;
  logic sdaBus;
  assign sdaBus = sdaM & ~sdaDriveLow;

  tuner_i2c_top dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .addrStrap(addrStrap),
    .porEvent(porEvent), .lockIn(lockIn), .sdaDriveLow(sdaDriveLow),
    .divWord(divWord), .cpCurrent(cpCurrent), .refRatio(refRatio),
    .testMode(testMode), .oscSel(oscSel), .pathSel(pathSel),
    .refBufEn(refBufEn), .portP0(portP0)
  );

  localparam int Q = 25;
  localparam logic [7:0] WR = 8'hC4;  // prefix 11000, strap 10, write
  localparam logic [7:0] RD = 8'hC5;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  string expTag[$];
  logic [7:0] expVal[$];
  logic [7:0] obsVal[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pairs observed bus items with expected ones
  initial begin
    forever begin
      @(negedge clk);
      while (obsVal.size() > 0) begin
        logic [7:0] o;
        o = obsVal.pop_front();
        if (expVal.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard actual=%0h expected=none", o);
        end else begin
          string t;
          logic [7:0] e;
          t = expTag.pop_front();
          e = expVal.pop_front();
          check(t, {24'b0, o}, {24'b0, e});
        end
      end
    end
  end

  task automatic quarter(); repeat (Q) @(negedge clk); endtask

  task automatic busStart();
    sdaM = 1'b1; quarter(); sclM = 1'b1; quarter();
    sdaM = 1'b0; quarter(); sclM = 1'b0; quarter();
  endtask

  task automatic busStop();
    sdaM = 1'b0; quarter(); sclM = 1'b1; quarter(); sdaM = 1'b1; quarter();
  endtask

  task automatic sendBit(logic b);
    sdaM = b; quarter(); sclM = 1'b1; quarter(); quarter(); sclM = 1'b0; quarter();
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; quarter(); sclM = 1'b1; quarter(); b = sdaBus; quarter();
    sclM = 1'b0; quarter();
  endtask

  // driver: push expected ack, send byte, push observed ack
  task automatic writeByte(string tag, logic [7:0] d, logic expAck);
    logic a;
    expTag.push_back(tag); expVal.push_back({7'b0, expAck});
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(a);
    obsVal.push_back({7'b0, a});
  endtask

  task automatic readByte(string tag, logic [7:0] exp, logic masterAck);
    logic [7:0] d;
    expTag.push_back(tag); expVal.push_back(exp);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recvBit(b);
      d[i] = b;
    end
    sendBit(masterAck);
    obsVal.push_back(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1; porEvent = 1'b0; lockIn = 1'b0;
    addrStrap = 2'b10;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 divWord", divWord, 0);
    check("R1 cpCurrent", cpCurrent, 0);
    check("R1 refRatio", refRatio, 0);
    check("R1 mode bits", {testMode, oscSel, pathSel}, 0);
    check("R1 refBufEn", refBufEn, 1);
    check("R1 portP0", portP0, 0);
    check("R1 sdaDriveLow", sdaDriveLow, 0);

    // R2 R3 R4: frequency pair, upper byte alone leaves divWord alone
    busStart();
    writeByte("R2 addr ack", WR, 1'b0);
    writeByte("R3 freq hi ack", 8'h12, 1'b0);
    check("R4 divWord held after upper byte", divWord, 0);
    writeByte("R3 freq lo ack", 8'h34, 1'b0);
    check("R3 divWord", divWord, 15'h1234);
    busStop();

    // R5 R6: control pair then frequency pair, no readdress
    busStart();
    writeByte("R2 addr ack", WR, 1'b0);
    writeByte("R5 ctrl A ack", 8'hCB, 1'b0);
    writeByte("R5 ctrl B ack", 8'hB9, 1'b0);
    check("R5 cpCurrent", cpCurrent, 2);
    check("R5 refRatio", refRatio, 5'h0B);
    check("R5 testMode", testMode, 5);
    check("R5 oscSel pathSel", {oscSel, pathSel}, 2'b11);
    check("R5 refBufEn portP0", {refBufEn, portP0}, 2'b01);
    writeByte("R6 freq hi ack", 8'h05, 1'b0);
    writeByte("R6 freq lo ack", 8'h67, 1'b0);
    check("R6 divWord second pair", divWord, 15'h0567);
    busStop();

    // R4: STOP after the upper byte commits it
    busStart();
    writeByte("R2 addr ack", WR, 1'b0);
    writeByte("R4 freq hi ack", 8'h7F, 1'b0);
    busStop();
    quarter();
    check("R4 divWord on stop", divWord, 15'h7F67);

    // R7: complete ctrl A, then 3 bits of ctrl B, then STOP
    busStart();
    writeByte("R2 addr ack", WR, 1'b0);
    writeByte("R7 ctrl A ack", 8'h81, 1'b0);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    busStop();
    quarter();
    check("R7 refRatio kept", {cpCurrent, refRatio}, {2'd0, 5'd1});
    check("R7 testMode kept", testMode, 5);
    check("R7 port bits kept", {oscSel, pathSel, refBufEn, portP0}, 4'b1101);

    // R2: strap mismatch, no ack and nothing written
    busStart();
    writeByte("R2 mismatch nack", 8'hC2, 1'b1);
    writeByte("R2 ignored byte nack", 8'h00, 1'b1);
    writeByte("R2 ignored byte2 nack", 8'h11, 1'b1);
    busStop();
    check("R2 divWord untouched", divWord, 15'h7F67);

    // R8 R9 R10: read status with POR set and lock high
    lockIn = 1'b1;
    busStart();
    writeByte("R2 read addr ack", RD, 1'b0);
    readByte("R8 status 1", 8'hC0, 1'b0);
    readByte("R8 status 2", 8'hC0, 1'b1);
    quarter();
    check("R9 released after nack", sdaDriveLow, 0);
    readByte("R9 idle after nack", 8'hFF, 1'b1);
    busStop();

    // R10: POR cleared, then set by porEvent
    busStart();
    writeByte("R2 read addr ack", RD, 1'b0);
    readByte("R10 por cleared", 8'h40, 1'b1);
    busStop();
    lockIn = 1'b0;
    porEvent = 1'b1; repeat (3) @(negedge clk); porEvent = 1'b0;
    busStart();
    writeByte("R2 read addr ack", RD, 1'b0);
    readByte("R10 por set by event", 8'h80, 1'b1);
    busStop();

    // R11: repeated START from write into read, pending upper bits kept
    busStart();
    writeByte("R2 addr ack", WR, 1'b0);
    writeByte("R11 freq hi ack", 8'h03, 1'b0);
    busStart();
    writeByte("R11 read addr ack", RD, 1'b0);
    readByte("R11 status after restart", 8'h00, 1'b1);
    check("R11 divWord held", divWord, 15'h7F67);
    busStop();
    quarter();
    check("R11 divWord on stop", divWord, 15'h0367);

    repeat (5) @(negedge clk);
    if (expVal.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", expVal.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule